// File: doc/BRIEF.md
# I2C Slave Address Recognizer

This block sits behind the synchronizers of an I2C slave port and decides whether the device is being addressed. It takes the bus clock and data lines as ordinary single-bit inputs, runs on a faster system clock, and finds bus conditions by comparing each input with its value one cycle earlier. The first byte after a START, or the first two bytes when 10-bit addressing is in use, is shifted in and compared against up to four sources. These are a primary address, which always takes part, a secondary address that has its own enable, the general call address 0000000 and the alert response address 0001100. Each of the two address registers has a mode bit that selects 7-bit or 10-bit format.

When an address matches, the block pulls SDA low for the acknowledge bit. It then reports that it is addressed, the direction taken from the R/W bit, and which source matched. When it accepts a 10-bit header byte, it issues a one-cycle pulse so that the byte is not treated as payload. A completed 10-bit write addressing leaves a record that survives a repeated START. A later header byte with R/W=1 that carries the same top address bits then addresses the device as a transmitter. A STOP, or a START on an idle bus, wipes that record. Any first byte after a repeated START that does not re-address the device also wipes it.

Top module: `i2c_addr_recog`

## Requirements
- R1: After reset, and on the clock after any STOP (SDA rising while SCL is high), `addressed` is 0, `match_src` is 0 (none) and `sda_pull` is 0.
- R2: A first byte whose upper seven bits equal `pri_addr[6:0]` is acknowledged when `pri_ten`=0. `match_src` becomes 1 (primary) and `is_read` equals bit 0 of the byte.
- R3: The secondary address (`sec_addr[6:0]` in 7-bit mode) is acknowledged, with `match_src`=2, only while `sec_en`=1.
- R4: The byte 0x00 (address 0000000, R/W=0) is acknowledged with `match_src`=3 only while `gcall_en`=1. Address 0000000 with R/W=1 is never acknowledged.
- R5: Address 0001100 is acknowledged with `match_src`=4 only while `alert_en`=1.
- R6: In 10-bit mode the header byte 11110, a[9], a[8], 0 is acknowledged without the device becoming addressed. A second byte equal to a[7:0] is then acknowledged and sets `addressed`=1, `is_read`=0 and the source of the matching register.
- R7: A header whose two address bits differ from every enabled 10-bit register is not acknowledged. A second byte that differs from a[7:0] is not acknowledged and leaves `addressed`=0. A 7-bit register never matches a byte whose top five bits are 11110.
- R8: After a completed 10-bit write addressing and a repeated START, the header 11110, a[9], a[8], 1 is acknowledged. The device becomes addressed with `is_read`=1 and the same source.
- R9: A header with R/W=1 is not acknowledged when the bus has seen a STOP, or a START on an idle bus, since the last 10-bit write addressing.
- R10: `hdr_skip` pulses for exactly one cycle for every acknowledged 10-bit header byte, and at no other time.
- R11: `sda_pull` rises only on the clock after SCL falls at the end of the eighth bit, and it is released after SCL falls at the end of the ninth bit.
- R12: A repeated START followed by a first byte that does not address the device clears the 10-bit record. A following header with R/W=1 is then not acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Synchronized bus clock |
| sda_i | input | 1 | Synchronized bus data, as seen on the wire |
| pri_addr | input | 10 | Primary slave address (bits 6:0 used in 7-bit mode) |
| pri_ten | input | 1 | Primary address is 10-bit |
| sec_addr | input | 10 | Secondary slave address |
| sec_en | input | 1 | Secondary address takes part in matching |
| sec_ten | input | 1 | Secondary address is 10-bit |
| gcall_en | input | 1 | General call takes part in matching |
| alert_en | input | 1 | Alert response address takes part in matching |
| sda_pull | output | 1 | Pull SDA low (acknowledge) |
| addressed | output | 1 | Device is addressed |
| is_read | output | 1 | Addressed as transmitter (R/W=1) |
| match_src | output | 3 | 0 none, 1 primary, 2 secondary, 3 general call, 4 alert |
| hdr_skip | output | 1 | One-cycle pulse: accepted byte is a 10-bit header, not data |

## Verification
The properties take the bus to be well formed. SDA changes only while SCL is low, except at START and STOP. Each SCL level lasts several system clocks, so that the acknowledge decision is settled before SCL falls. The enables and address registers stay constant from a START until the STOP that closes the transfer. The stimulus drives SCL and SDA on the falling system clock, holds each bus phase for at least four cycles, and writes the configuration only while the bus is idle. The monitor samples the outputs at the middle of the ninth SCL high phase, well after every decision has been made.

// File: rtl/i2c_ar_pkg.sv
package i2c_ar_pkg;
   typedef enum logic [2:0] {
      SRC_NONE  = 3'd0,
      SRC_PRI   = 3'd1,
      SRC_SEC   = 3'd2,
      SRC_GC    = 3'd3,
      SRC_ALERT = 3'd4
   } src_e;

   typedef enum logic [1:0] {
      PH_IDLE   = 2'd0,
      PH_FIRST  = 2'd1,
      PH_SECOND = 2'd2,
      PH_HOLD   = 2'd3
   } phase_e;
endpackage

// File: rtl/i2c_ar_buscond.sv
module i2c_ar_buscond (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic cond_start,
   output logic cond_stop,
   output logic scl_rise,
   output logic scl_fall
);
   logic scl_q, sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_i;
         sda_q <= sda_i;
      end
   end

   assign cond_start = scl_q & scl_i & sda_q & ~sda_i;
   assign cond_stop  = scl_q & scl_i & ~sda_q & sda_i;
   assign scl_rise   = ~scl_q & scl_i;
   assign scl_fall   = scl_q & ~scl_i;
endmodule

// File: rtl/i2c_ar_shifter.sv
module i2c_ar_shifter #(
   parameter int BITS = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cond_start,
   input  logic            cond_stop,
   input  logic            scl_rise,
   input  logic            scl_fall,
   input  logic            sda_i,
   output logic [BITS-1:0] rx_byte,
   output logic            byte_rdy,
   output logic            ack_start,
   output logic            ack_end
);
   localparam int CNT_W = $clog2(BITS + 2);
   localparam logic [CNT_W-1:0] LAST   = CNT_W'(BITS - 1);
   localparam logic [CNT_W-1:0] FULL   = CNT_W'(BITS);
   localparam logic [CNT_W-1:0] ACKBIT = CNT_W'(BITS + 1);

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt      <= '0;
         rx_byte  <= '0;
         byte_rdy <= 1'b0;
      end else begin
         byte_rdy <= 1'b0;
         if (cond_start || cond_stop) begin
            cnt <= '0;
         end else if (scl_rise && cnt < FULL) begin
            rx_byte  <= {rx_byte[BITS-2:0], sda_i};
            cnt      <= cnt + 1'b1;
            byte_rdy <= (cnt == LAST);
         end else if (scl_fall && cnt == FULL) begin
            cnt <= ACKBIT;
         end else if (scl_fall && cnt == ACKBIT) begin
            cnt <= '0;
         end
      end
   end

   assign ack_start = scl_fall && cnt == FULL;
   assign ack_end   = scl_fall && cnt == ACKBIT;
endmodule

// File: rtl/i2c_ar_slot.sv
module i2c_ar_slot #(
   parameter int          AW  = 10,
   parameter logic [4:0]  PFX = 5'b11110
) (
   input  logic [AW-1:0] addr,
   input  logic          en,
   input  logic          ten,
   input  logic [7:0]    rx,
   output logic          hit7,
   output logic          hit_hi,
   output logic          hit_lo
);
   assign hit7   = en & ~ten & (rx[7:1] == addr[6:0]);
   assign hit_hi = en & ten & (rx[7:3] == PFX) & (rx[2:1] == addr[AW-1 -: 2]);
   assign hit_lo = en & ten & (rx == addr[7:0]);
endmodule

// File: rtl/i2c_addr_recog.sv
module i2c_addr_recog #(
   parameter int         AW         = 10,
   parameter logic [6:0] GCALL_ADDR = 7'h00,
   parameter logic [6:0] ALERT_ADDR = 7'h0C,
   parameter logic [4:0] TEN_PFX    = 5'b11110
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          scl_i,
   input  logic          sda_i,
   input  logic [AW-1:0] pri_addr,
   input  logic          pri_ten,
   input  logic [AW-1:0] sec_addr,
   input  logic          sec_en,
   input  logic          sec_ten,
   input  logic          gcall_en,
   input  logic          alert_en,
   output logic          sda_pull,
   output logic          addressed,
   output logic          is_read,
   output logic [2:0]    match_src,
   output logic          hdr_skip
);
   import i2c_ar_pkg::*;

   localparam int NSLOT  = 2;
   localparam int BYTE_W = 8;

   generate
      if (AW != 10) begin : g_bad_aw
         $error("i2c_addr_recog: AW must be 10");
      end
      if (TEN_PFX[4:3] != 2'b11) begin : g_bad_pfx
         $error("i2c_addr_recog: TEN_PFX must be a reserved 11xxx pattern");
      end
   endgenerate

   logic cond_start, cond_stop, scl_rise, scl_fall;
   logic [BYTE_W-1:0] rx_byte;
   logic byte_rdy, ack_start, ack_end;

   i2c_ar_buscond u_cond (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
      .cond_start(cond_start), .cond_stop(cond_stop),
      .scl_rise(scl_rise), .scl_fall(scl_fall)
   );

   i2c_ar_shifter #(.BITS(BYTE_W)) u_shift (
      .clk(clk), .rst_n(rst_n), .cond_start(cond_start), .cond_stop(cond_stop),
      .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_i(sda_i),
      .rx_byte(rx_byte), .byte_rdy(byte_rdy),
      .ack_start(ack_start), .ack_end(ack_end)
   );

   logic [AW-1:0]    s_addr [NSLOT];
   logic [NSLOT-1:0] s_en, s_ten, hit7, hit_hi, hit_lo;

   assign s_addr[0] = pri_addr;
   assign s_addr[1] = sec_addr;
   assign s_en      = {sec_en, 1'b1};
   assign s_ten     = {sec_ten, pri_ten};

   genvar k;
   generate
      for (k = 0; k < NSLOT; k++) begin : g_slot
         i2c_ar_slot #(.AW(AW), .PFX(TEN_PFX)) u_slot (
            .addr(s_addr[k]), .en(s_en[k]), .ten(s_ten[k]), .rx(rx_byte),
            .hit7(hit7[k]), .hit_hi(hit_hi[k]), .hit_lo(hit_lo[k])
         );
      end
   endgenerate

   phase_e           ph;
   logic             busy, rec_valid, rec_idx, ack_pend, ack_q, skip_q;
   logic [NSLOT-1:0] pend;
   src_e             src_q;
   logic             addr_q, rd_q;

   logic             is_hdr, rw;
   logic             d_ack, d_adr, d_rd, d_skip, d_rec, d_rec_idx;
   src_e             d_src;
   phase_e           d_ph;
   logic [NSLOT-1:0] d_pend, sel;

   assign is_hdr = (rx_byte[7:3] == TEN_PFX);
   assign rw     = rx_byte[0];
   assign sel    = pend & hit_lo;

   always_comb begin
      d_ack     = 1'b0;
      d_adr     = 1'b0;
      d_rd      = 1'b0;
      d_skip    = 1'b0;
      d_src     = SRC_NONE;
      d_ph      = PH_HOLD;
      d_pend    = '0;
      d_rec     = rec_valid;
      d_rec_idx = rec_idx;
      case (ph)
         PH_FIRST: begin
            d_rec = 1'b0;
            if (is_hdr) begin
               if (!rw) begin
                  d_pend = hit_hi;
                  if (|hit_hi) begin
                     d_ack  = 1'b1;
                     d_skip = 1'b1;
                     d_ph   = PH_SECOND;
                  end
               end else if (rec_valid && hit_hi[rec_idx]) begin
                  d_ack  = 1'b1;
                  d_skip = 1'b1;
                  d_adr  = 1'b1;
                  d_rd   = 1'b1;
                  d_rec  = 1'b1;
                  d_src  = rec_idx ? SRC_SEC : SRC_PRI;
               end
            end else begin
               d_rd = rw;
               if (hit7[0])                                    d_src = SRC_PRI;
               else if (hit7[1])                               d_src = SRC_SEC;
               else if (gcall_en && !rw && rx_byte[7:1] == GCALL_ADDR) d_src = SRC_GC;
               else if (alert_en && rx_byte[7:1] == ALERT_ADDR) d_src = SRC_ALERT;
               d_ack = (d_src != SRC_NONE);
               d_adr = d_ack;
            end
         end
         PH_SECOND: begin
            if (|sel) begin
               d_ack     = 1'b1;
               d_adr     = 1'b1;
               d_rec     = 1'b1;
               d_rec_idx = ~sel[0];
               d_src     = sel[0] ? SRC_PRI : SRC_SEC;
            end
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph        <= PH_IDLE;
         busy      <= 1'b0;
         rec_valid <= 1'b0;
         rec_idx   <= 1'b0;
         pend      <= '0;
         ack_pend  <= 1'b0;
         ack_q     <= 1'b0;
         skip_q    <= 1'b0;
         addr_q    <= 1'b0;
         rd_q      <= 1'b0;
         src_q     <= SRC_NONE;
      end else begin
         skip_q <= 1'b0;
         if (cond_start) begin
            ph       <= PH_FIRST;
            busy     <= 1'b1;
            ack_pend <= 1'b0;
            ack_q    <= 1'b0;
            addr_q   <= 1'b0;
            rd_q     <= 1'b0;
            src_q    <= SRC_NONE;
            if (!busy) rec_valid <= 1'b0;
         end else if (cond_stop) begin
            ph        <= PH_IDLE;
            busy      <= 1'b0;
            rec_valid <= 1'b0;
            ack_pend  <= 1'b0;
            ack_q     <= 1'b0;
            addr_q    <= 1'b0;
            rd_q      <= 1'b0;
            src_q     <= SRC_NONE;
         end else begin
            if (byte_rdy && (ph == PH_FIRST || ph == PH_SECOND)) begin
               ph        <= d_ph;
               pend      <= d_pend;
               ack_pend  <= d_ack;
               skip_q    <= d_skip;
               rec_valid <= d_rec;
               rec_idx   <= d_rec_idx;
               if (d_adr) begin
                  addr_q <= 1'b1;
                  rd_q   <= d_rd;
                  src_q  <= d_src;
               end
            end
            if (ack_start && ack_pend) begin
               ack_q    <= 1'b1;
               ack_pend <= 1'b0;
            end else if (ack_end) begin
               ack_q <= 1'b0;
            end
         end
      end
   end

   assign sda_pull  = ack_q;
   assign addressed = addr_q;
   assign is_read   = rd_q;
   assign match_src = src_q;
   assign hdr_skip  = skip_q;
endmodule

// File: rtl/i2c_ar_chk.sv
module i2c_ar_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       scl_i,
   input logic       sda_i,
   input logic       sec_en,
   input logic       gcall_en,
   input logic       alert_en,
   input logic       sda_pull,
   input logic       addressed,
   input logic       is_read,
   input logic [2:0] match_src,
   input logic       hdr_skip
);
   import i2c_ar_pkg::*;

   assert_stop_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (scl_i && $past(scl_i) && sda_i && !$past(sda_i)) |=> (!addressed && match_src == SRC_NONE));

   assert_sec_needs_en_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (match_src == SRC_SEC) |-> sec_en);

   assert_gc_write_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (match_src == SRC_GC) |-> (gcall_en && !is_read));

   assert_alert_needs_en_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (match_src == SRC_ALERT) |-> alert_en);

   assert_skip_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
      hdr_skip |=> !hdr_skip);

   assert_pull_after_fall_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_pull) |-> ($past(scl_i, 2) && !$past(scl_i)));

   assert_pull_scl_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sda_pull) |-> !scl_i);
endmodule

bind i2c_addr_recog i2c_ar_chk u_chk (
   .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
   .sec_en(sec_en), .gcall_en(gcall_en), .alert_en(alert_en),
   .sda_pull(sda_pull), .addressed(addressed), .is_read(is_read),
   .match_src(match_src), .hdr_skip(hdr_skip)
);

// File: tb/sim_i2c_addr_recog.sv
module sim_i2c_addr_recog;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl_m = 1'b1;
   logic sda_m = 1'b1;
   logic sda_bus;
   logic [9:0] pri_addr = 10'h02A;
   logic pri_ten = 1'b0;
   logic [9:0] sec_addr = 10'h033;
   logic sec_en = 1'b0, sec_ten = 1'b0, gcall_en = 1'b0, alert_en = 1'b0;
   logic sda_pull, addressed, is_read, hdr_skip;
   logic [2:0] match_src;

   int checks = 0;
   int errors = 0;
   int skip_seen = 0;
   int skip_exp = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   assign sda_bus = sda_m & ~sda_pull;

   i2c_addr_recog u0 (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
      .pri_addr(pri_addr), .pri_ten(pri_ten), .sec_addr(sec_addr),
      .sec_en(sec_en), .sec_ten(sec_ten), .gcall_en(gcall_en), .alert_en(alert_en),
      .sda_pull(sda_pull), .addressed(addressed), .is_read(is_read),
      .match_src(match_src), .hdr_skip(hdr_skip)
   );

   typedef struct {
      logic       ack;
      logic       adr;
      logic [2:0] src;
      logic       rd;
      int         skips;
      string      tag;
   } item_t;

   item_t exp_q[$];
   item_t obs;
   event  obs_ev;

   task automatic chk(input bit ok, input string tag, input string what,
                      input int act, input int expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
      end
   endtask

   always @(negedge clk) if (rst_n && hdr_skip) skip_seen++;

   // monitor: pops the expected item and compares with the sampled result
   initial begin
      forever begin
         @(obs_ev);
         if (exp_q.size() == 0) begin
            chk(1'b0, obs.tag, "unexpected result", 1, 0);
         end else begin
            item_t e;
            e = exp_q.pop_front();
            chk(obs.ack == e.ack, e.tag, "ack", int'(obs.ack), int'(e.ack));
            chk(obs.adr == e.adr, e.tag, "addressed", int'(obs.adr), int'(e.adr));
            chk(obs.src == e.src, e.tag, "match_src", int'(obs.src), int'(e.src));
            chk(obs.rd == e.rd, e.tag, "is_read", int'(obs.rd), int'(e.rd));
            chk(obs.skips == e.skips, e.tag, "hdr_skip count", obs.skips, e.skips);
         end
      end
   end

   task automatic hold(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_start();
      sda_m = 1'b1; scl_m = 1'b1; hold(4);
      sda_m = 1'b0; hold(4);
      scl_m = 1'b0; hold(4);
   endtask

   task automatic bus_rstart();
      sda_m = 1'b1; hold(4);
      scl_m = 1'b1; hold(4);
      sda_m = 1'b0; hold(4);
      scl_m = 1'b0; hold(4);
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; hold(4);
      scl_m = 1'b1; hold(4);
      sda_m = 1'b1; hold(6);
      chk(addressed == 1'b0 && match_src == 3'd0, "R1", "state after STOP",
          int'(addressed), 0);
   endtask

   task automatic send_byte(input logic [7:0] b, input string tag);
      for (int i = 7; i >= 0; i--) begin
         sda_m = b[i]; hold(4);
         scl_m = 1'b1; hold(4);
         scl_m = 1'b0; hold(4);
      end
      sda_m = 1'b1; hold(4);
      scl_m = 1'b1; hold(2);
      obs.ack   = ~sda_bus;
      obs.adr   = addressed;
      obs.src   = match_src;
      obs.rd    = is_read;
      obs.skips = skip_seen;
      obs.tag   = tag;
      ->obs_ev;
      hold(2);
      scl_m = 1'b0; hold(4);
      chk(sda_pull == 1'b0, "R11", "pull released after ninth clock", int'(sda_pull), 0);
   endtask

   // driver: pushes the expected outcome, then drives the byte
   task automatic xfer(input logic [7:0] b, input logic e_ack, input logic e_adr,
                       input logic [2:0] e_src, input logic e_rd, input int skip_inc,
                       input string tag);
      item_t e;
      skip_exp += skip_inc;
      e.ack = e_ack; e.adr = e_adr; e.src = e_src; e.rd = e_rd;
      e.skips = skip_exp; e.tag = tag;
      exp_q.push_back(e);
      send_byte(b, tag);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      hold(5);
      rst_n = 1'b1;
      hold(3);
      chk(sda_pull == 1'b0, "R1", "reset sda_pull", int'(sda_pull), 0);
      chk(addressed == 1'b0, "R1", "reset addressed", int'(addressed), 0);
      chk(match_src == 3'd0, "R1", "reset match_src", int'(match_src), 0);

      // R2 primary 7-bit write, read and miss
      bus_start(); xfer(8'h54, 1, 1, 3'd1, 0, 0, "R2 write"); bus_stop();
      bus_start(); xfer(8'h55, 1, 1, 3'd1, 1, 0, "R2 read");  bus_stop();
      bus_start(); xfer(8'h56, 0, 0, 3'd0, 0, 0, "R2 miss");  bus_stop();

      // R3 secondary enable
      bus_start(); xfer(8'h66, 0, 0, 3'd0, 0, 0, "R3 disabled"); bus_stop();
      sec_en = 1'b1;
      bus_start(); xfer(8'h66, 1, 1, 3'd2, 0, 0, "R3 enabled"); bus_stop();

      // R4 general call
      bus_start(); xfer(8'h00, 0, 0, 3'd0, 0, 0, "R4 disabled"); bus_stop();
      gcall_en = 1'b1;
      bus_start(); xfer(8'h00, 1, 1, 3'd3, 0, 0, "R4 enabled"); bus_stop();
      bus_start(); xfer(8'h01, 0, 0, 3'd0, 0, 0, "R4 read rejected"); bus_stop();

      // R5 alert response
      bus_start(); xfer(8'h19, 0, 0, 3'd0, 0, 0, "R5 disabled"); bus_stop();
      alert_en = 1'b1;
      bus_start(); xfer(8'h19, 1, 1, 3'd4, 1, 0, "R5 enabled"); bus_stop();

      // R6 / R8 / R10 ten-bit write then read after repeated START
      pri_addr = 10'h2B5; pri_ten = 1'b1;
      bus_start();
      xfer(8'hF4, 1, 0, 3'd0, 0, 1, "R6 header R10");
      xfer(8'hB5, 1, 1, 3'd1, 0, 0, "R6 low byte");
      bus_rstart();
      xfer(8'hF5, 1, 1, 3'd1, 1, 1, "R8 read header R10");
      bus_stop();

      // R9 record gone after STOP
      bus_start(); xfer(8'hF5, 0, 0, 3'd0, 0, 0, "R9 after stop"); bus_stop();

      // R7 mismatches
      bus_start(); xfer(8'hF6, 0, 0, 3'd0, 0, 0, "R7 high bits"); bus_stop();
      bus_start();
      xfer(8'hF4, 1, 0, 3'd0, 0, 1, "R7 header R10");
      xfer(8'hB4, 0, 0, 3'd0, 0, 0, "R7 low byte");
      bus_stop();

      // R12 repeated START to another address clears the record
      bus_start();
      xfer(8'hF4, 1, 0, 3'd0, 0, 1, "R12 header");
      xfer(8'hB5, 1, 1, 3'd1, 0, 0, "R12 low byte");
      bus_rstart();
      xfer(8'h20, 0, 0, 3'd0, 0, 0, "R12 other address");
      bus_rstart();
      xfer(8'hF5, 0, 0, 3'd0, 0, 0, "R12 read refused");
      bus_stop();

      // R9 / R7 fresh header with R/W=1, and 7-bit slot never matching 11110XX
      pri_addr = 10'h02A; pri_ten = 1'b0;
      sec_addr = 10'h07A; sec_ten = 1'b0;
      bus_start(); xfer(8'hF5, 0, 0, 3'd0, 0, 0, "R9 no record"); bus_stop();
      bus_start(); xfer(8'hF4, 0, 0, 3'd0, 0, 0, "R7 seven-bit vs 11110"); bus_stop();

      hold(10);
      chk(exp_q.size() == 0, "R2", "scoreboard drained", exp_q.size(), 0);
      chk(skip_seen == skip_exp, "R10", "total hdr_skip pulses", skip_seen, skip_exp);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule